// File: doc/BRIEF.md
# Banked Host Register Window with Packet Memory Pointer Port

The block presents sixteen byte offsets to a host. One offset holds a bank selector, another returns a fixed identity byte, and the other offsets are decoded against the active bank. Only the packet-access bank is decoded here. It holds a page number register, a 16-bit pointer register and four data offsets. A data access drives a byte-wide port into a paged packet buffer.

The pointer has two flag bits. One chooses the page: either the page at the head of the receive queue, which a neighbouring block supplies, or the page held in the page number register. The other flag turns on auto-increment. With auto-increment on, every data access uses the pointer address and then steps the low address field. With it off, the four data offsets reach four consecutive bytes after the pointer address, and the pointer does not move.

Hosts can issue 8-, 16- or 32-bit accesses. A front-end sequencer turns each access into single-byte steps, lowest byte first, one step per clock. It then returns the gathered read data with a one-cycle completion pulse. A 32-bit write aimed at offset 12 is a special case: only its upper half-word is applied, and that half reaches the bank selector.

Top module: `reg_window`

## Requirements
- R1: Byte offsets inside a multi-byte access are computed modulo 16. A 32-bit read at offset 14 returns offset 14 in bits 7:0, offset 15 in bits 15:8, offset 0 in bits 23:16 and offset 1 in bits 31:24.
- R2: Offset 14 is the bank selector in every bank. Writing it stores the 8-bit value, and reading it returns that value.
- R3: Offset 15 always reads 0x33. Writes to offset 15 have no effect.
- R4: In bank 2, offset 2 is a read/write page number register. Offset 6 is the low pointer byte and offset 7 is the high pointer byte. A read of the high byte returns it ANDed with 0xF7.
- R5: When pointer bit 15 is 1, data accesses go to the page given by the receive-queue head input. When it is 0, they go to the page in the low bits of the page number register.
- R6: When pointer bit 14 is 0, a data access at offset 8+k (k = 0..3) uses byte address (pointer[10:0] + k) mod 2048, and the pointer keeps its value.
- R7: When pointer bit 14 is 1, a data access uses byte address pointer[10:0] whatever the offset. After the access, pointer[10:0] increases by one and wraps from 0x7FF to 0. Bits 15:11 are left unchanged.
- R8: A data write drives the memory write strobe with the written byte. A data read returns the memory byte at the selected page and address.
- R9: When the bank selector is not 2, offsets 0 to 13 read as zero. Writes to them change neither the pointer nor the memory.
- R10: Each access is split into byte steps, one per clock, at rising offsets: 1 step for size 0, 2 for size 1 and 4 for size 2. The completion pulse comes one cycle after the last step. Read bytes are packed little-endian.
- R11: A 32-bit write at offset 12 performs only two steps. Bits 23:16 go to offset 14 and bits 31:24 go to offset 15.
- R12: After reset the bank selector, pointer and page number register read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_req_i | input | 1 | Access request; accepted while not busy |
| host_we_i | input | 1 | 1 = write, 0 = read |
| host_size_i | input | 2 | 0 byte, 1 half-word, 2 word |
| host_addr_i | input | 4 | Starting byte offset |
| host_wdata_i | input | 32 | Write data, byte 0 in bits 7:0 |
| host_busy_o | output | 1 | Sequencer is stepping an access |
| host_done_o | output | 1 | One-cycle completion pulse |
| host_rdata_o | output | 32 | Gathered read data, valid with done |
| rxq_head_i | input | PAGE_W | Page at the head of the receive queue |
| mem_en_o | output | 1 | Packet memory access this cycle |
| mem_we_o | output | 1 | Packet memory write strobe |
| mem_page_o | output | PAGE_W | Selected page |
| mem_addr_o | output | BYTE_AW | Byte address within the page |
| mem_wdata_o | output | 8 | Write byte |
| mem_rdata_i | input | 8 | Read byte, combinational from memory |

## Verification
An access with N byte steps is accepted on the first rising edge that sees the request. Its steps run on the next N edges, and done rises after the last of them. A driver holding the request from one falling edge therefore sees done at the (N+1)th falling edge after that. The driver places each expected read word and this expected latency in a queue before it raises the request. A monitor samples on falling edges, pops one entry per done pulse, and compares both the latency and the data. Memory side effects are checked against the bench's own buffer model once the access has completed.

// File: rtl/reg_window_pkg.sv
package reg_window_pkg;
  localparam logic [3:0] OFF_PNUM   = 4'd2;
  localparam logic [3:0] OFF_PTR_LO = 4'd6;
  localparam logic [3:0] OFF_PTR_HI = 4'd7;
  localparam logic [3:0] OFF_WIDE_W = 4'd12;
  localparam logic [3:0] OFF_BANK   = 4'd14;
  localparam logic [3:0] OFF_ID     = 4'd15;
  localparam logic [1:0] DATA_GRP   = 2'b10;   // offsets 8..11
  localparam logic [7:0] ID_BYTE    = 8'h33;
  localparam logic [7:0] PTR_HI_MSK = 8'hF7;
  localparam logic [7:0] DATA_BANK  = 8'd2;
  localparam int unsigned PTR_RXQ   = 15;
  localparam int unsigned PTR_AUTO  = 14;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;
endpackage

// File: rtl/byte_sequencer.sv
module byte_sequencer
  import reg_window_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [1:0]  size_i,
  input  logic [3:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [31:0] rdata_o,
  output logic        b_en_o,
  output logic        b_we_o,
  output logic [3:0]  b_off_o,
  output logic [7:0]  b_wdata_o,
  input  logic [7:0]  b_rdata_i
);
  logic        busy_q, done_q, we_q;
  logic [1:0]  beat_q, last_q;
  logic [3:0]  base_q;
  logic [31:0] wdata_q, rdata_q;
  acc_size_e   size;
  logic        accept, last_beat;

  assign size      = acc_size_e'(size_i);
  assign accept    = req_i && !busy_q;
  assign last_beat = busy_q && (beat_q == last_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      we_q    <= 1'b0;
      beat_q  <= '0;
      last_q  <= '0;
      base_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q  <= 1'b1;
        we_q    <= we_i;
        base_q  <= addr_i;
        wdata_q <= wdata_i;
        rdata_q <= '0;
        // word write at 12 only carries its upper half
        beat_q  <= (we_i && size == SZ_WORD && addr_i == OFF_WIDE_W) ? 2'd2 : 2'd0;
        case (size)
          SZ_BYTE: last_q <= 2'd0;
          SZ_HALF: last_q <= 2'd1;
          default: last_q <= 2'd3;
        endcase
      end else if (busy_q) begin
        if (!we_q) rdata_q[8*beat_q +: 8] <= b_rdata_i;
        if (last_beat) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          beat_q <= beat_q + 2'd1;
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign rdata_o   = rdata_q;
  assign b_en_o    = busy_q;
  assign b_we_o    = busy_q && we_q;
  assign b_off_o   = base_q + {2'b00, beat_q};
  assign b_wdata_o = wdata_q[8*beat_q +: 8];

  a_r10_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_beat |=> (done_o && !busy_o));
  a_r11_upper_half_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && we_i && size_i == 2'd2 && addr_i == 4'd12) |=> (b_off_o == 4'd14));
endmodule

// File: rtl/ptr_port.sv
module ptr_port
  import reg_window_pkg::*;
#(
  parameter int unsigned PAGES      = 4,
  parameter int unsigned PAGE_BYTES = 2048,
  localparam int unsigned PAGE_W    = $clog2(PAGES),
  localparam int unsigned BYTE_AW   = $clog2(PAGE_BYTES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               acc_i,
  input  logic               we_i,
  input  logic [3:0]         off_i,
  input  logic [7:0]         wdata_i,
  input  logic [PAGE_W-1:0]  page_num_i,
  input  logic [PAGE_W-1:0]  rxq_head_i,
  output logic [15:0]        ptr_o,
  output logic               mem_en_o,
  output logic               mem_we_o,
  output logic [PAGE_W-1:0]  mem_page_o,
  output logic [BYTE_AW-1:0] mem_addr_o,
  output logic [7:0]         mem_wdata_o
);
  logic [15:0]        ptr_q;
  logic               data_hit, auto_inc;
  logic [BYTE_AW-1:0] base_addr;

  assign data_hit  = acc_i && (off_i[3:2] == DATA_GRP);
  assign auto_inc  = ptr_q[PTR_AUTO];
  assign base_addr = ptr_q[BYTE_AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (acc_i && we_i && off_i == OFF_PTR_LO) begin
      ptr_q[7:0] <= wdata_i;
    end else if (acc_i && we_i && off_i == OFF_PTR_HI) begin
      ptr_q[15:8] <= wdata_i;
    end else if (data_hit && auto_inc) begin
      ptr_q[BYTE_AW-1:0] <= base_addr + 1'b1;
    end
  end

  assign ptr_o       = ptr_q;
  assign mem_en_o    = data_hit;
  assign mem_we_o    = data_hit && we_i;
  assign mem_page_o  = ptr_q[PTR_RXQ] ? rxq_head_i : page_num_i;
  assign mem_addr_o  = auto_inc ? base_addr : base_addr + BYTE_AW'(off_i[1:0]);
  assign mem_wdata_o = wdata_i;

  a_r7_auto_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_hit && auto_inc) |=> (ptr_q[BYTE_AW-1:0] == BYTE_AW'($past(ptr_q[BYTE_AW-1:0]) + 1'b1)
                                && ptr_q[15:BYTE_AW] == $past(ptr_q[15:BYTE_AW])));
  a_r6_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_hit && !auto_inc) |=> $stable(ptr_q));
  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_i |=> $stable(ptr_q));
endmodule

// File: rtl/reg_window.sv
module reg_window
  import reg_window_pkg::*;
#(
  parameter int unsigned PAGES      = 4,
  parameter int unsigned PAGE_BYTES = 2048,
  localparam int unsigned PAGE_W    = $clog2(PAGES),
  localparam int unsigned BYTE_AW   = $clog2(PAGE_BYTES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               host_req_i,
  input  logic               host_we_i,
  input  logic [1:0]         host_size_i,
  input  logic [3:0]         host_addr_i,
  input  logic [31:0]        host_wdata_i,
  output logic               host_busy_o,
  output logic               host_done_o,
  output logic [31:0]        host_rdata_o,
  input  logic [PAGE_W-1:0]  rxq_head_i,
  output logic               mem_en_o,
  output logic               mem_we_o,
  output logic [PAGE_W-1:0]  mem_page_o,
  output logic [BYTE_AW-1:0] mem_addr_o,
  output logic [7:0]         mem_wdata_o,
  input  logic [7:0]         mem_rdata_i
);
  logic        b_en, b_we;
  logic [3:0]  b_off;
  logic [7:0]  b_wdata, b_rdata;
  logic [7:0]  bank_q, pnum_q;
  logic [15:0] ptr;
  logic        in_data_bank;

  byte_sequencer u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (host_req_i),
    .we_i      (host_we_i),
    .size_i    (host_size_i),
    .addr_i    (host_addr_i),
    .wdata_i   (host_wdata_i),
    .busy_o    (host_busy_o),
    .done_o    (host_done_o),
    .rdata_o   (host_rdata_o),
    .b_en_o    (b_en),
    .b_we_o    (b_we),
    .b_off_o   (b_off),
    .b_wdata_o (b_wdata),
    .b_rdata_i (b_rdata)
  );

  assign in_data_bank = (bank_q == DATA_BANK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q <= '0;
      pnum_q <= '0;
    end else if (b_en && b_we) begin
      if (b_off == OFF_BANK) bank_q <= b_wdata;
      else if (in_data_bank && b_off == OFF_PNUM) pnum_q <= b_wdata;
    end
  end

  ptr_port #(.PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES)) u_ptr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_i       (b_en && in_data_bank),
    .we_i        (b_we),
    .off_i       (b_off),
    .wdata_i     (b_wdata),
    .page_num_i  (pnum_q[PAGE_W-1:0]),
    .rxq_head_i  (rxq_head_i),
    .ptr_o       (ptr),
    .mem_en_o    (mem_en_o),
    .mem_we_o    (mem_we_o),
    .mem_page_o  (mem_page_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o)
  );

  always_comb begin
    b_rdata = '0;
    if (b_off == OFF_BANK)      b_rdata = bank_q;
    else if (b_off == OFF_ID)   b_rdata = ID_BYTE;
    else if (in_data_bank) begin
      if (b_off == OFF_PNUM)            b_rdata = pnum_q;
      else if (b_off == OFF_PTR_LO)     b_rdata = ptr[7:0];
      else if (b_off == OFF_PTR_HI)     b_rdata = ptr[15:8] & PTR_HI_MSK;
      else if (b_off[3:2] == DATA_GRP)  b_rdata = mem_rdata_i;
    end
  end

  a_r2_bank_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_en && b_we && b_off == OFF_BANK) |=> (bank_q == $past(b_wdata)));
  a_r9_mem_only_in_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o |-> (b_en && in_data_bank));
endmodule

// File: tb/reg_window_test.sv
`timescale 1ns/1ps
module reg_window_test;
  localparam int PW = 2;
  localparam int AW = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  size = 2'd0;
  logic [3:0]  addr = 4'd0;
  logic [31:0] wdata = '0;
  logic        busy, done;
  logic [31:0] rdata;
  logic [PW-1:0] rxq = '0;
  logic        mem_en, mem_we;
  logic [PW-1:0] mem_page;
  logic [AW-1:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  logic [7:0]  bmem [4][2048];
  int          memw_cnt = 0;
  int          cyc = 0;
  int          n_cmp = 0, n_bad = 0;

  typedef struct {
    bit          chk;
    logic [31:0] exp;
    int          lat;
    int          start;
    string       tag;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  reg_window uut (
    .clk_i(clk), .rst_ni(rst_n),
    .host_req_i(req), .host_we_i(we), .host_size_i(size), .host_addr_i(addr),
    .host_wdata_i(wdata), .host_busy_o(busy), .host_done_o(done), .host_rdata_o(rdata),
    .rxq_head_i(rxq), .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_page_o(mem_page),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  assign mem_rdata = bmem[mem_page][mem_addr];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_we) begin
      bmem[mem_page][mem_addr] <= mem_wdata;
      memw_cnt <= memw_cnt + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops one expectation per completion pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        check("R10 unexpected done", 32'd1, 32'd0);
      end else begin
        item_t it;
        it = sb.pop_front();
        if (it.lat != 0) check({it.tag, " latency"}, cyc - it.start, it.lat);
        if (it.chk) check(it.tag, rdata, it.exp);
      end
    end
  end

  task automatic xfer(input bit w, input logic [1:0] sz, input logic [3:0] a,
                      input logic [31:0] d, input bit c, input logic [31:0] e,
                      input int lat, input string tag);
    item_t it;
    it.chk = c; it.exp = e; it.lat = lat; it.start = cyc; it.tag = tag;
    sb.push_back(it);
    req = 1'b1; we = w; size = sz; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0;
    do @(negedge clk); while (!done);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    xfer(1'b1, 2'd0, a, {24'd0, d}, 1'b0, '0, 2, "R10 byte write");
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
    xfer(1'b0, 2'd0, a, '0, 1'b1, {24'd0, e}, 2, tag);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int mw;
    for (int p = 0; p < 4; p++)
      for (int i = 0; i < 2048; i++) bmem[p][i] = 8'h00;
    bmem[1][11'h000] = 8'hC3;
    bmem[1][11'h7FE] = 8'h3C;
    bmem[1][11'h100] = 8'h01;
    bmem[1][11'h101] = 8'h02;
    bmem[1][11'h102] = 8'h03;
    bmem[1][11'h103] = 8'h04;
    bmem[3][11'h041] = 8'h99;
    bmem[2][11'h041] = 8'hAB;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    rd(4'hE, 8'h00, "R12 bank after reset");
    wr(4'hE, 8'h02);
    rd(4'hE, 8'h02, "R2 bank readback");
    rd(4'h6, 8'h00, "R12 ptr lo after reset");
    rd(4'h7, 8'h00, "R12 ptr hi after reset");
    rd(4'h2, 8'h00, "R12 page num after reset");

    // R3 identity
    wr(4'hF, 8'h55);
    rd(4'hF, 8'h33, "R3 identity byte");
    rd(4'hE, 8'h02, "R3 write to 15 leaves bank");

    // R4 registers
    wr(4'h2, 8'h05);
    rd(4'h2, 8'h05, "R4 page num");
    wr(4'h6, 8'h34);
    wr(4'h7, 8'hFF);
    rd(4'h6, 8'h34, "R4 ptr lo");
    rd(4'h7, 8'hF7, "R4 ptr hi masked");

    // R6 fixed pointer, page from page num
    wr(4'h2, 8'h01);
    wr(4'h6, 8'h10);
    wr(4'h7, 8'h00);
    wr(4'h8, 8'hA0);
    wr(4'h9, 8'hA1);
    wr(4'hA, 8'hA2);
    wr(4'hB, 8'hA3);
    check("R6 byte +0", bmem[1][11'h010], 8'hA0);
    check("R6 byte +1", bmem[1][11'h011], 8'hA1);
    check("R8 byte +2", bmem[1][11'h012], 8'hA2);
    check("R6 byte +3", bmem[1][11'h013], 8'hA3);
    rd(4'h6, 8'h10, "R6 ptr held");
    wr(4'h6, 8'hFE);
    wr(4'h7, 8'h07);
    wr(4'hB, 8'h5A);
    check("R6 address wrap", bmem[1][11'h001], 8'h5A);
    rd(4'hA, 8'hC3, "R6 wrapped read");
    rd(4'h8, 8'h3C, "R8 data read");

    // R7 auto increment
    wr(4'h6, 8'h20);
    wr(4'h7, 8'h40);
    wr(4'h8, 8'h11);
    wr(4'hA, 8'h22);
    check("R7 first auto write", bmem[1][11'h020], 8'h11);
    check("R7 offset ignored", bmem[1][11'h021], 8'h22);
    rd(4'h6, 8'h22, "R7 ptr lo stepped");
    rd(4'h7, 8'h40, "R7 ptr hi kept");
    wr(4'h6, 8'hFF);
    wr(4'h7, 8'h57);
    wr(4'h9, 8'h66);
    check("R7 write at top", bmem[1][11'h7FF], 8'h66);
    rd(4'h6, 8'h00, "R7 low field wraps");
    rd(4'h7, 8'h50, "R7 upper bits kept");
    wr(4'h6, 8'h00);
    wr(4'h7, 8'h41);
    xfer(1'b0, 2'd2, 4'h8, '0, 1'b1, 32'h04030201, 5, "R10 word auto read");
    rd(4'h6, 8'h04, "R7 four steps");

    // R5 receive-queue page
    rxq = 2'd3;
    wr(4'h6, 8'h40);
    wr(4'h7, 8'h80);
    wr(4'h8, 8'h77);
    check("R5 rx head page written", bmem[3][11'h040], 8'h77);
    check("R5 page num page untouched", bmem[1][11'h040], 8'h00);
    rd(4'h9, 8'h99, "R5 rx head page read");
    rxq = 2'd2;
    rd(4'h9, 8'hAB, "R5 follows head input");

    // R9 other banks
    wr(4'hE, 8'h01);
    mw = memw_cnt;
    wr(4'h6, 8'h12);
    wr(4'h8, 8'hEE);
    rd(4'h8, 8'h00, "R9 data offset reads zero");
    rd(4'h6, 8'h00, "R9 ptr offset reads zero");
    check("R9 no memory write", memw_cnt, mw);
    wr(4'hE, 8'h02);
    rd(4'h6, 8'h40, "R9 ptr unchanged");

    // R10 multi-byte
    xfer(1'b1, 2'd1, 4'h6, 32'h00004123, 1'b0, '0, 3, "R10 half write");
    xfer(1'b0, 2'd1, 4'h6, '0, 1'b1, 32'h00004123, 3, "R10 half read");
    xfer(1'b0, 2'd1, 4'hE, '0, 1'b1, 32'h00003302, 3, "R10 half read top");
    xfer(1'b0, 2'd2, 4'hC, '0, 1'b1, 32'h33020000, 5, "R10 word read");
    xfer(1'b0, 2'd2, 4'hE, '0, 1'b1, 32'h00003302, 5, "R1 offset wrap");
    xfer(1'b1, 2'd2, 4'h4, 32'h5A120000, 1'b0, '0, 5, "R10 word write");
    rd(4'h6, 8'h12, "R10 word write lo");
    rd(4'h7, 8'h52, "R10 word write hi");

    // R11 word write at offset 12
    xfer(1'b1, 2'd2, 4'hC, 32'h0001FFFF, 1'b0, '0, 3, "R11 upper half only");
    rd(4'hE, 8'h01, "R11 bank from bits 23:16");

    repeat (3) @(negedge clk);
    check("R10 all completions seen", sb.size(), 0);
    summary();
    $finish;
  end
endmodule